// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides whether a received Ethernet frame should be kept, based only on its 48-bit destination address. A parser upstream presents the address with a one-cycle strobe. The block then sorts the address into one of three classes: broadcast, multicast or unicast. It compares the address against the programmed station address and looks the address up in a 64-entry imperfect hash table.

Six independent enable bits decide which of these results may admit the frame. One clock after the strobe, the block reports an accept flag and a six-bit vector that shows which enabled criteria matched. The surrounding receive path uses the accept flag to keep or drop the frame. It can use the reason vector for statistics or for steering.

Top module: `dst_addr_filter`

## Requirements
- R1: After synchronous reset, `res_valid`, `accept` and every bit of `reason` are 0. Because all enable bits are 0 at reset, the filter rejects everything until software sets them.
- R2: `res_valid` equals the value `addr_valid` had one clock earlier. In a cycle where `res_valid` is 0, `accept` and `reason` are also 0.
- R3: The address is classified as follows:
  - Broadcast: all 48 bits are one.
  - Multicast: bit 40 (the least significant bit of the first octet, `dst_addr[47:40]`) is one and the address is not broadcast.
  - Unicast: any other address.
- R4: `reason[0]` is set when `filter_ctrl[0]` is 1 and the address is unicast.
- R5: `reason[1]` is set when `filter_ctrl[1]` is 1 and the address is broadcast.
- R6: `reason[2]` is set when `filter_ctrl[2]` is 1 and the address is multicast. A broadcast address does not count as multicast.
- R7: The hash index is defined as follows:
  - The CRC is computed over the six octets, first octet first, bits of each octet least significant first.
  - The register is reflected, uses polynomial 0xEDB88320, starts from 0xFFFFFFFF and has no final inversion.
  - The index is bits 28:23 of the resulting register.
  - `reason[3]` is set when `filter_ctrl[3]` is 1, the address is unicast and `hash_table[index]` is 1.
- R8: `reason[4]` is set when `filter_ctrl[4]` is 1, the address is multicast (not broadcast) and `hash_table[index]` is 1.
- R9: `reason[5]` is set when `filter_ctrl[5]` is 1 and `dst_addr` equals `station_addr` in all 48 bits, whatever the address class.
- R10: `accept` is the OR of all six `reason` bits. If `filter_ctrl[5:0]` is zero, every frame is rejected.
- R11: `filter_ctrl[11:6]` has no effect on `accept` or `reason`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_valid | input | 1 | Destination address strobe |
| dst_addr | input | 48 | Destination address, first octet in bits 47:40 |
| station_addr | input | 48 | Programmed station address |
| hash_table | input | 64 | Imperfect hash table, one bit per index |
| filter_ctrl | input | 12 | Enable bits 5:0; bits 11:6 reserved |
| res_valid | output | 1 | Result valid, one cycle after the strobe |
| accept | output | 1 | Frame accepted |
| reason | output | 6 | Per-criterion match flags |

## Verification
The bench aims at the following corner cases. Each is listed with the fault it would expose:

- **All-ones broadcast address.** A classifier that checks only the group bit would call it multicast. It would then wrongly set the multicast and multicast-hash reasons.
- **Hash table with a single bit set at the computed index, and its complement.** A wrong CRC bit order, seed or index slice accepts the wrong frames under one of the two tables.
- **Station-address match on a multicast address.** This shows that the exact match ignores class.
- **Reserved control bits set.** A design that decodes them would change the result.
- **Idle cycles after each strobe.** Outputs that are held rather than cleared would show up here.

// File: rtl/dafilt_pkg.sv
package dafilt_pkg;

    localparam int ADDR_W     = 48;
    localparam int OCTETS     = ADDR_W / 8;
    localparam int HASH_W     = 64;
    localparam int IDX_W      = $clog2(HASH_W);
    localparam int CTRL_W     = 12;
    localparam int N_CRIT     = 6;
    localparam int IDX_LSB    = 23;
    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;
    localparam logic [31:0] CRC_SEED      = 32'hFFFF_FFFF;

    typedef enum logic [1:0] {
        CLS_UNI   = 2'd0,
        CLS_MULTI = 2'd1,
        CLS_BCAST = 2'd2
    } addr_class_e;

    // Criterion slots, in the bit order of the enable and reason vectors.
    typedef struct packed {
        logic perfect;
        logic mc_hash;
        logic uc_hash;
        logic mc_all;
        logic bc_all;
        logic uc_all;
    } crit_t;

    // Reflected CRC-32 over the address octets, first octet first, LSB first.
    function automatic logic [IDX_W-1:0] hash_index(input logic [ADDR_W-1:0] a);
        logic [31:0] crc;
        logic [7:0]  oct;
        logic        fb;
        crc = CRC_SEED;
        for (int i = 0; i < OCTETS; i++) begin
            oct = a[ADDR_W-1-8*i -: 8];
            for (int b = 0; b < 8; b++) begin
                fb  = crc[0] ^ oct[b];
                crc = crc >> 1;
                if (fb) crc = crc ^ CRC_POLY_REFL;
            end
        end
        return crc[IDX_LSB +: IDX_W];
    endfunction

endpackage

// File: rtl/dafilt_classify.sv
module dafilt_classify
    import dafilt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    output addr_class_e       cls
);
    localparam int GROUP_BIT = ADDR_W - 8;

    always_comb begin
        if (&addr)                cls = CLS_BCAST;
        else if (addr[GROUP_BIT]) cls = CLS_MULTI;
        else                      cls = CLS_UNI;
    end

    // A unicast result never carries the group bit (R3)
    assert_uni_no_group_R3: assert property (@(posedge clk) disable iff (rst)
        (cls == CLS_UNI) |-> !addr[GROUP_BIT]);
    // Broadcast is reported exactly when the address is all ones (R3)
    assert_bcast_allones_R3: assert property (@(posedge clk) disable iff (rst)
        (cls == CLS_BCAST) == (addr == {ADDR_W{1'b1}}));

endmodule

// File: rtl/dafilt_hash.sv
module dafilt_hash
    import dafilt_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [HASH_W-1:0] table_bits,
    output logic [IDX_W-1:0]  idx,
    output logic              hit
);
    always_comb begin
        idx = hash_index(addr);
        hit = table_bits[idx];
    end
endmodule

// File: rtl/dst_addr_filter.sv
module dst_addr_filter
    import dafilt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_valid,
    input  logic [47:0]       dst_addr,
    input  logic [47:0]       station_addr,
    input  logic [63:0]       hash_table,
    input  logic [11:0]       filter_ctrl,
    output logic              res_valid,
    output logic              accept,
    output logic [5:0]        reason
);
    addr_class_e       cls;
    logic [IDX_W-1:0]  hidx;
    logic              hhit;
    logic              station_eq;
    crit_t             crit_raw;
    crit_t             crit_en;
    crit_t             crit_q;
    logic              accept_q;
    logic              valid_q;
    logic              unused_rsvd;

    dafilt_classify u_cls (
        .clk  (clk),
        .rst  (rst),
        .addr (dst_addr),
        .cls  (cls)
    );

    dafilt_hash u_hash (
        .addr       (dst_addr),
        .table_bits (hash_table),
        .idx        (hidx),
        .hit        (hhit)
    );

    assign station_eq  = (dst_addr == station_addr);
    assign unused_rsvd = ^{filter_ctrl[CTRL_W-1:N_CRIT], hidx};

    always_comb begin
        crit_raw.uc_all  = (cls == CLS_UNI);
        crit_raw.bc_all  = (cls == CLS_BCAST);
        crit_raw.mc_all  = (cls == CLS_MULTI);
        crit_raw.uc_hash = (cls == CLS_UNI)   && hhit;
        crit_raw.mc_hash = (cls == CLS_MULTI) && hhit;
        crit_raw.perfect = station_eq;
        crit_en          = crit_raw & crit_t'(filter_ctrl[N_CRIT-1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q  <= 1'b0;
            crit_q   <= '0;
            accept_q <= 1'b0;
        end else begin
            valid_q <= addr_valid;
            if (addr_valid) begin
                crit_q   <= crit_en;
                accept_q <= |crit_en;
            end else begin
                crit_q   <= '0;
                accept_q <= 1'b0;
            end
        end
    end

    assign res_valid = valid_q;
    assign accept    = accept_q;
    assign reason    = crit_q;

    // Result strobe trails the input strobe by one clock (R2)
    assert_valid_lag_R2: assert property (@(posedge clk) disable iff (rst)
        ##1 res_valid == $past(addr_valid));
    // No result state outside a valid cycle (R2)
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> (!accept && reason == '0));
    // A reason bit only appears when its enable was set (R4..R9)
    assert_reason_enabled_R4: assert property (@(posedge clk) disable iff (rst)
        ##1 res_valid |-> ((reason & ~$past(filter_ctrl[N_CRIT-1:0])) == '0));
    // Accept tracks the reason vector (R10)
    assert_accept_or_R10: assert property (@(posedge clk) disable iff (rst)
        accept == (reason != '0));
    // Zero enables reject the frame (R10)
    assert_zero_ctrl_reject_R10: assert property (@(posedge clk) disable iff (rst)
        ##1 (res_valid && $past(filter_ctrl[N_CRIT-1:0]) == '0) |-> !accept);
    // Broadcast and multicast reasons never coexist (R6)
    assert_bc_mc_excl_R6: assert property (@(posedge clk) disable iff (rst)
        !(reason[1] && (reason[2] || reason[4])));

endmodule

// File: tb/dst_addr_filter_tb.sv
module dst_addr_filter_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        addr_valid;
    logic [47:0] dst_addr;
    logic [47:0] station_addr;
    logic [63:0] hash_table;
    logic [11:0] filter_ctrl;
    logic        res_valid;
    logic        accept;
    logic [5:0]  reason;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    dst_addr_filter u_dut (
        .clk          (clk),
        .rst          (rst),
        .addr_valid   (addr_valid),
        .dst_addr     (dst_addr),
        .station_addr (station_addr),
        .hash_table   (hash_table),
        .filter_ctrl  (filter_ctrl),
        .res_valid    (res_valid),
        .accept       (accept),
        .reason       (reason)
    );

    // Forward (non-reflected) CRC, then bit reversal to match the reflected register.
    function automatic logic [5:0] ref_index(input logic [47:0] a);
        logic [31:0] c;
        logic [31:0] r;
        logic [7:0]  o;
        logic        fb;
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < 6; i++) begin
            o = a[47-8*i -: 8];
            for (int b = 0; b < 8; b++) begin
                fb = c[31] ^ o[b];
                c  = c << 1;
                if (fb) c = c ^ 32'h04C1_1DB7;
            end
        end
        for (int k = 0; k < 32; k++) r[k] = c[31-k];
        return r[28:23];
    endfunction

    function automatic logic [5:0] ref_reason(input logic [47:0] a, input logic [47:0] st,
                                              input logic [63:0] tb, input logic [11:0] ct);
        logic bc, mc, uc, h;
        logic [5:0] r;
        bc = (a == 48'hFFFF_FFFF_FFFF);
        mc = a[40] && !bc;
        uc = !bc && !mc;
        h  = tb[ref_index(a)];
        r[0] = ct[0] && uc;
        r[1] = ct[1] && bc;
        r[2] = ct[2] && mc;
        r[3] = ct[3] && uc && h;
        r[4] = ct[4] && mc && h;
        r[5] = ct[5] && (a == st);
        return r;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Present one address for one cycle and check the result the next cycle.
    task automatic probe(input string req, input logic [47:0] a, input logic [11:0] ct);
        logic [5:0] er;
        er = ref_reason(a, station_addr, hash_table, ct);
        @(negedge clk);
        dst_addr    = a;
        filter_ctrl = ct;
        addr_valid  = 1'b1;
        @(negedge clk);
        addr_valid  = 1'b0;
        check({req, " R2 valid"}, {7'd0, res_valid}, 8'd1);
        check({req, " reason"},   {2'd0, reason},    {2'd0, er});
        check({req, " R10 accept"}, {7'd0, accept},  {7'd0, |er});
    endtask

    task automatic idle_check();
        @(negedge clk);
        check("R2 idle", {res_valid, accept, reason}, 8'd0);
    endtask

    function automatic logic [47:0] rnd_addr(input int kind);
        logic [47:0] a;
        a = {$urandom, $urandom} ;
        case (kind)
            0: a[40] = 1'b0;
            1: begin a[40] = 1'b1; if (&a) a[0] = 1'b0; end
            default: a = 48'hFFFF_FFFF_FFFF;
        endcase
        return a;
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [47:0] a;
        logic [5:0]  ix;
        void'($urandom(32'd1234));
        rst = 1'b1; addr_valid = 1'b0; dst_addr = '0;
        station_addr = 48'h0200_1122_3344; hash_table = '0; filter_ctrl = '0;
        repeat (3) @(negedge clk);
        check("R1 reset", {res_valid, accept, reason}, 8'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", {res_valid, accept, reason}, 8'd0);

        // R10: zero enables reject every class
        hash_table = '1;
        probe("R10 zero uc", 48'h0200_1122_3344, 12'h000);
        probe("R10 zero bc", 48'hFFFF_FFFF_FFFF, 12'h000);
        idle_check();

        // R3/R5/R6: broadcast is not multicast
        probe("R5 bc", 48'hFFFF_FFFF_FFFF, 12'h03F);
        check("R5 bc bit", {7'd0, reason[1]}, 8'd1);
        check("R6 bc not mc", {6'd0, reason[4], reason[2]}, 8'd0);
        idle_check();

        // R4 unicast promiscuous, R6 multicast promiscuous
        probe("R4 uc", 48'h0000_0000_0001, 12'h001);
        probe("R6 mc", 48'h0100_5E00_0001, 12'h004);
        probe("R3 mc group bit", 48'h0100_0000_0000, 12'h001);

        // R7/R8: single-bit table at computed index and its complement
        a  = 48'h0A1B_2C3D_4E5F;
        ix = ref_index(a);
        hash_table = 64'd1 << ix;
        probe("R7 hash hit", a, 12'h008);
        check("R7 hit bit", {7'd0, reason[3]}, 8'd1);
        hash_table = ~(64'd1 << ix);
        probe("R7 hash miss", a, 12'h008);
        check("R7 miss bit", {7'd0, reason[3]}, 8'd0);
        a  = 48'h0100_5E7F_0A0B;
        ix = ref_index(a);
        hash_table = 64'd1 << ix;
        probe("R8 hash hit", a, 12'h010);
        check("R8 hit bit", {7'd0, reason[4]}, 8'd1);
        hash_table = ~(64'd1 << ix);
        probe("R8 hash miss", a, 12'h010);
        probe("R8 uc hash off for mc", a, 12'h008);

        // R9: perfect match, including a multicast station address
        probe("R9 perfect", 48'h0200_1122_3344, 12'h020);
        check("R9 bit", {7'd0, reason[5]}, 8'd1);
        station_addr = 48'h0300_AABB_CCDD;
        probe("R9 mc perfect", 48'h0300_AABB_CCDD, 12'h020);
        probe("R9 off by one", 48'h0300_AABB_CCDC, 12'h020);

        // R11: reserved bits have no effect
        probe("R11 rsvd uc", 48'h0000_1111_2222, 12'hFC0);
        check("R11 rsvd accept", {7'd0, accept}, 8'd0);
        probe("R11 rsvd mix", 48'h0300_AABB_CCDD, 12'hFE4);
        idle_check();

        // Random mix
        for (int n = 0; n < 1500; n++) begin
            int kind;
            kind = int'($urandom % 7) ;
            hash_table = {$urandom, $urandom};
            a = rnd_addr(kind < 3 ? 0 : (kind < 6 ? 1 : 2));
            if ($urandom % 5 == 0) station_addr = a;
            else station_addr = {$urandom, $urandom};
            probe("R3-mix random", a, 12'($urandom));
            if ($urandom % 4 == 0) idle_check();
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule